// File: doc/BRIEF.md
# Beam-Synchronised Display Coprocessor

This block is a small list processor. It runs a program of two-word instructions that it reads from memory, and it keeps its register writes in step with the video beam. It reads memory through a request/grant port and raises a request only in every other memory slot, so each instruction costs four slots when grants are given. There are three instruction kinds. A register move puts an immediate word onto an outgoing write bus. A wait holds the processor off the bus until the beam reaches a masked position. A conditional skip drops the next instruction if that position has already been reached.

A host loads the program counter through a small register window. Two 18-bit location registers hold start addresses, and a strobe address for each one copies it into the program counter. The program can write these strobes itself to jump. The start of vertical blank always restarts the program from the first location. Register moves are range-protected: the lowest destinations can never be written, and the next range can be written only while a host-set danger bit is on. A blocked move halts the processor until the next restart.

Top module: `beam_copro`

## Requirements
- R1: After reset the block is idle: mem_req, wr_en and halted are low, and it stays idle until a jump strobe or vblank_start. The danger bit is clear after reset.
- R2: mem_req is never high in two consecutive cycles. Each instruction takes two granted reads, so with mem_gnt held high, back-to-back moves produce wr_en pulses exactly 4 cycles apart.
- R3: A move has first-word bit 0 = 0. First-word bits 8:1 are the destination and the second word is the data. A permitted move gives one wr_en pulse carrying that destination and data, in program order.
- R4: A wait has first-word bit 0 = 1 and second-word bit 0 = 0. The target sits in first-word bits 15:8 (vertical 7:0) and 7:1 (horizontal 8:2). The masks sit in second-word bits 14:8 (vertical 6:0) and 7:1 (horizontal 8:2). The wait ends once {v7, masked v6:0, masked h8:2} of the beam is greater than or equal to the same packing of the target, with the vertical part more significant.
- R5: Vertical bit 7 always takes part in the comparison, whatever the mask bits are.
- R6: When second-word bit 15 is 0, blit_done must also be high before a wait ends or a skip is taken. When bit 15 is 1, blit_done is ignored.
- R7: A skip (first-word bit 0 = 1, second-word bit 0 = 1) whose condition holds drops the next instruction. If the condition does not hold, the next instruction runs.
- R8: A write, by the host or by a move, to address 0x54 (or 0x55) loads the program counter from location 1 (or location 2). Location n is written at 0x50+2(n-1) (high part from data bits 1:0, address bits 17:16) and at 0x51+2(n-1) (address bits 15:0). A strobe written by a move does not appear on the write bus.
- R9: A vblank_start pulse restarts execution from location 1 at any time, including during a wait. Changing location 1 alone does not restart.
- R10: Move destinations 0x00–0x1F are never written. Destinations 0x20–0x3F are written only while the danger bit (host address 0x1A, data bit 0) is set.
- R11: A blocked move raises halted, produces no write, and stops all memory requests until the next strobe or vblank_start.
- R12: The program counter moves forward one word per granted fetch and wraps from 0x3FFFF to 0x00000.
- R13: A fetch completes only in a cycle where mem_req and mem_gnt are both high. With mem_gnt low, execution makes no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 16 | Host write data |
| vblank_start | input | 1 | Start-of-vertical-blank pulse |
| blit_done | input | 1 | Blitter-finished flag |
| beam_v | input | 8 | Vertical beam position bits 7:0 |
| beam_hc | input | 7 | Horizontal beam position bits 8:2 |
| mem_req | output | 1 | Instruction read request |
| mem_addr | output | 18 | Instruction word address |
| mem_gnt | input | 1 | Read grant; data valid in the same cycle |
| mem_rdata | input | 16 | Instruction word read data |
| wr_en | output | 1 | Register write pulse from a move |
| wr_addr | output | 8 | Register write destination |
| wr_data | output | 16 | Register write data |
| halted | output | 1 | Halted after a blocked move |

## Verification
The bench builds the block with its default 18-bit address and 16-bit word. It backs it with a 256-word memory indexed by the low address bits, so that programs placed at the top of the address space run across the wrap point. Horizontal wait targets are swept in steps across the whole 7-bit range. At each step the beam sits just below the target and then exactly on it, and the bench works out the expected exit from the packed comparison. Separate programs reach the unmaskable vertical bit, the blitter qualifier, both outcomes of a skip, both protection ranges, jumps through the strobes and vblank restarts.

// File: rtl/copro_pkg.sv
package copro_pkg;
    localparam int WORD_W = 16;
    localparam int PC_W   = 18;
    localparam int RA_W   = 8;
    localparam int HI_W   = PC_W - WORD_W;

    localparam logic [RA_W-1:0] A_CTRL    = 8'h1A;
    localparam logic [RA_W-1:0] A_LOC1_HI = 8'h50;
    localparam logic [RA_W-1:0] A_LOC1_LO = 8'h51;
    localparam logic [RA_W-1:0] A_LOC2_HI = 8'h52;
    localparam logic [RA_W-1:0] A_LOC2_LO = 8'h53;
    localparam logic [RA_W-1:0] A_JMP1    = 8'h54;
    localparam logic [RA_W-1:0] A_JMP2    = 8'h55;

    localparam logic [RA_W-1:0] LIM_NEVER  = 8'h20;
    localparam logic [RA_W-1:0] LIM_DANGER = 8'h40;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH1, S_FETCH2, S_WAIT, S_HALT
    } cstate_t;

    // first word of a compare instruction
    typedef struct packed {
        logic [7:0] vpos;
        logic [6:0] hpos;
        logic       is_cmp;
    } cmp_w1_t;

    // second word of a compare instruction
    typedef struct packed {
        logic       no_blit;
        logic [6:0] vmask;
        logic [6:0] hmask;
        logic       is_skip;
    } cmp_w2_t;

    function automatic logic move_allowed(logic [RA_W-1:0] dst, logic danger);
        if (dst < LIM_NEVER)  return 1'b0;
        if (dst < LIM_DANGER) return danger;
        return 1'b1;
    endfunction
endpackage

// File: rtl/copro_cond.sv
module copro_cond
    import copro_pkg::*;
(
    input  cmp_w1_t    tgt,
    input  cmp_w2_t    ctl,
    input  logic [7:0] beam_v,
    input  logic [6:0] beam_hc,
    input  logic       blit_done,
    output logic       reached
);
    logic [14:0] pos, goal;

    // vertical bit 7 bypasses the mask; the rest is masked per bit
    always_comb begin
        pos[14]  = beam_v[7];
        goal[14] = tgt.vpos[7];
        for (int i = 0; i < 7; i++) begin
            pos[7 + i]  = beam_v[i]   & ctl.vmask[i];
            goal[7 + i] = tgt.vpos[i] & ctl.vmask[i];
            pos[i]      = beam_hc[i]  & ctl.hmask[i];
            goal[i]     = tgt.hpos[i] & ctl.hmask[i];
        end
        reached = (pos >= goal) && (ctl.no_blit || blit_done);
    end
endmodule

// File: rtl/copro_regs.sv
module copro_regs
    import copro_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [RA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              mv_we,
    input  logic [RA_W-1:0]   mv_addr,
    input  logic [WORD_W-1:0] mv_data,
    output logic [PC_W-1:0]   loc1,
    output logic [PC_W-1:0]   loc2,
    output logic              danger,
    output logic              jump1,
    output logic              jump2
);
    logic [WORD_W-HI_W-1:0] unused_hi_bits;
    assign unused_hi_bits = host_wdata[WORD_W-1:HI_W] ^ mv_data[WORD_W-1:HI_W];

    assign jump1 = (host_we && host_addr == A_JMP1) || (mv_we && mv_addr == A_JMP1);
    assign jump2 = (host_we && host_addr == A_JMP2) || (mv_we && mv_addr == A_JMP2);

    // both sources decode alike; the host is applied last and wins a clash
    always_ff @(posedge clk) begin
        if (rst) begin
            loc1   <= '0;
            loc2   <= '0;
            danger <= 1'b0;
        end else begin
            if (mv_we) begin
                case (mv_addr)
                    A_LOC1_HI: loc1[PC_W-1:WORD_W] <= mv_data[HI_W-1:0];
                    A_LOC1_LO: loc1[WORD_W-1:0]    <= mv_data;
                    A_LOC2_HI: loc2[PC_W-1:WORD_W] <= mv_data[HI_W-1:0];
                    A_LOC2_LO: loc2[WORD_W-1:0]    <= mv_data;
                    default: ;
                endcase
            end
            if (host_we) begin
                case (host_addr)
                    A_CTRL:    danger              <= host_wdata[0];
                    A_LOC1_HI: loc1[PC_W-1:WORD_W] <= host_wdata[HI_W-1:0];
                    A_LOC1_LO: loc1[WORD_W-1:0]    <= host_wdata;
                    A_LOC2_HI: loc2[PC_W-1:WORD_W] <= host_wdata[HI_W-1:0];
                    A_LOC2_LO: loc2[WORD_W-1:0]    <= host_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R10: a move never reaches the danger bit, so only the host changes it
    a_r10_danger_host_only: assert property (@(posedge clk) disable iff (rst)
        (danger != $past(danger)) |-> $past(host_we));
endmodule

// File: rtl/beam_copro.sv
module beam_copro
    import copro_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [RA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              vblank_start,
    input  logic              blit_done,
    input  logic [7:0]        beam_v,
    input  logic [6:0]        beam_hc,
    output logic              mem_req,
    output logic [PC_W-1:0]   mem_addr,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [RA_W-1:0]   wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              halted
);
    cstate_t           state_q;
    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] ir1_q, ir2_q;
    logic              skip_q, odd_q;
    logic [PC_W-1:0]   loc1, loc2;
    logic              danger, jump1, jump2, reached, got;
    logic              is_move, ok_move, mv_we;
    logic [RA_W-1:0]   dst;
    cmp_w2_t           ctl;

    assign mem_req  = odd_q && (state_q == S_FETCH1 || state_q == S_FETCH2);
    assign mem_addr = pc_q;
    assign halted   = (state_q == S_HALT);
    assign got      = mem_req && mem_gnt;
    assign is_move  = !ir1_q[0];
    assign dst      = ir1_q[RA_W:1];
    assign ok_move  = move_allowed(dst, danger);
    assign mv_we    = (state_q == S_FETCH2) && got && is_move && !skip_q && ok_move;
    assign ctl      = cmp_w2_t'((state_q == S_WAIT) ? ir2_q : mem_rdata);

    copro_regs u_regs (
        .clk, .rst, .host_we, .host_addr, .host_wdata,
        .mv_we, .mv_addr(dst), .mv_data(mem_rdata),
        .loc1, .loc2, .danger, .jump1, .jump2
    );

    copro_cond u_cond (
        .tgt(cmp_w1_t'(ir1_q)), .ctl, .beam_v, .beam_hc, .blit_done, .reached
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            ir1_q   <= '0;
            ir2_q   <= '0;
            skip_q  <= 1'b0;
            odd_q   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            odd_q <= ~odd_q;
            wr_en <= 1'b0;
            if (vblank_start || jump1 || jump2) begin
                pc_q    <= (vblank_start || jump1) ? loc1 : loc2;
                state_q <= S_FETCH1;
                skip_q  <= 1'b0;
            end else begin
                case (state_q)
                    S_FETCH1: if (got) begin
                        ir1_q   <= mem_rdata;
                        pc_q    <= pc_q + 1'b1;
                        state_q <= S_FETCH2;
                    end
                    S_FETCH2: if (got) begin
                        pc_q    <= pc_q + 1'b1;
                        state_q <= S_FETCH1;
                        if (skip_q) begin
                            skip_q <= 1'b0;
                        end else if (is_move) begin
                            if (ok_move) begin
                                wr_en   <= 1'b1;
                                wr_addr <= dst;
                                wr_data <= mem_rdata;
                            end else begin
                                state_q <= S_HALT;
                            end
                        end else if (ctl.is_skip) begin
                            skip_q <= reached;
                        end else if (!reached) begin
                            ir2_q   <= mem_rdata;
                            state_q <= S_WAIT;
                        end
                    end
                    S_WAIT: if (reached) state_q <= S_FETCH1;
                    default: ;
                endcase
            end
        end
    end

    // R2: requests only in alternate slots
    a_r2_req_spacing: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R10: the lowest destinations never reach the bus
    a_r10_never_low: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr >= LIM_NEVER));
    // R10: the guarded range needs the danger bit at decode time
    a_r10_guarded: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr < LIM_DANGER) |-> $past(danger));
    // R11: a halted processor leaves memory alone
    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);
    // R12: one word forward per granted fetch, wrapping
    a_r12_pc_step: assert property (@(posedge clk) disable iff (rst)
        (got && !vblank_start && !jump1 && !jump2) |=>
        (mem_addr == PC_W'($past(mem_addr) + 1'b1)));
endmodule

// File: tb/tb_beam_copro.sv
module tb_beam_copro;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        vbl = 1'b0;
    logic        blit_done = 1'b0;
    logic [7:0]  beam_v = '0;
    logic [6:0]  beam_hc = '0;
    logic        mem_req, mem_gnt, wr_en, halted;
    logic [17:0] mem_addr;
    logic [15:0] mem_rdata, wr_data;
    logic [7:0]  wr_addr;
    logic        gnt_en = 1'b1;

    logic [15:0] mem [0:255];
    int checks = 0, errors = 0, cyc = 0;
    int wcount = 0;
    logic [7:0]  wl_addr [0:15];
    logic [15:0] wl_data [0:15];
    int          wl_cyc  [0:15];

    always #5 clk = ~clk;

    assign mem_gnt   = gnt_en;
    assign mem_rdata = mem[mem_addr[7:0]];

    beam_copro dut (
        .clk, .rst, .host_we, .host_addr, .host_wdata,
        .vblank_start(vbl), .blit_done, .beam_v, .beam_hc,
        .mem_req, .mem_addr, .mem_gnt, .mem_rdata,
        .wr_en, .wr_addr, .wr_data, .halted
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (wr_en && wcount < 16) begin
        wl_addr[wcount] = wr_addr;
        wl_data[wcount] = wr_data;
        wl_cyc[wcount]  = cyc;
        wcount++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic start(input logic [17:0] at);
        hwrite(8'h50, {14'd0, at[17:16]});
        hwrite(8'h51, at[15:0]);
        wcount = 0;
        hwrite(8'h54, 16'h0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_move(input int at, input logic [7:0] d, input logic [15:0] v);
        mem[at[7:0]]        = {7'd0, d, 1'b0};
        mem[8'(at + 1)]     = v;
    endtask

    task automatic put_cmp(input int at, input logic [7:0] vp, input logic [6:0] hp,
                           input logic nb, input logic [6:0] vm, input logic [6:0] hm,
                           input logic sk);
        mem[at[7:0]]    = {vp, hp, 1'b1};
        mem[8'(at + 1)] = {nb, vm, hm, sk};
    endtask

    task automatic put_park(input int at);
        put_cmp(at, 8'hFF, 7'h7F, 1'b1, 7'h7F, 7'h7F, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(10);
        // R1: idle after reset
        chk(!mem_req && !wr_en && !halted && wcount == 0, "R1 reset idle",
            {mem_req, wr_en, halted}, 0);

        // R3/R2: three moves in order, 4 cycles apart
        put_move(8'h10, 8'h80, 16'h1234);
        put_move(8'h12, 8'h81, 16'hABCD);
        put_move(8'h14, 8'hC0, 16'h0F0F);
        put_park(8'h16);
        start(18'h00010);
        idle(40);
        chk(wcount == 3, "R3 move count", wcount, 3);
        chk(wl_addr[0] == 8'h80 && wl_data[0] == 16'h1234, "R3 first move", wl_data[0], 16'h1234);
        chk(wl_addr[1] == 8'h81 && wl_data[1] == 16'hABCD, "R3 second move", wl_data[1], 16'hABCD);
        chk(wl_addr[2] == 8'hC0 && wl_data[2] == 16'h0F0F, "R3 third move", wl_addr[2], 8'hC0);
        chk(wl_cyc[1] - wl_cyc[0] == 4, "R2 spacing a", wl_cyc[1] - wl_cyc[0], 4);
        chk(wl_cyc[2] - wl_cyc[1] == 4, "R2 spacing b", wl_cyc[2] - wl_cyc[1], 4);

        // R13: no grant, no progress
        gnt_en = 1'b0;
        start(18'h00010);
        idle(40);
        chk(wcount == 0, "R13 withheld grant", wcount, 0);
        gnt_en = 1'b1;
        idle(40);
        chk(wcount == 3, "R13 resumed", wcount, 3);

        // R10/R11: lowest range blocked and halts
        put_move(8'h40, 8'h10, 16'h0001);
        put_move(8'h42, 8'h82, 16'h0002);
        put_park(8'h44);
        start(18'h00040);
        idle(40);
        chk(wcount == 0, "R10 low range blocked", wcount, 0);
        chk(halted, "R11 halted", halted, 1);
        chk(!mem_req, "R11 no request", mem_req, 0);

        // R10: guarded range without and with danger bit
        put_move(8'h48, 8'h30, 16'h0005);
        put_move(8'h4A, 8'h83, 16'h0006);
        put_park(8'h4C);
        start(18'h00048);
        idle(40);
        chk(wcount == 0 && halted, "R10 guarded without danger", wcount, 0);
        hwrite(8'h1A, 16'h0001);
        start(18'h00048);
        idle(40);
        chk(wcount == 2 && wl_addr[0] == 8'h30, "R10 guarded with danger", wl_addr[0], 8'h30);
        chk(!halted, "R11 strobe clears halt", halted, 0);
        hwrite(8'h1A, 16'h0000);

        // R4: horizontal sweep, beam just below then on target
        for (int t = 1; t < 128; t += 7) begin
            put_cmp(8'h60, 8'h20, 7'(t), 1'b1, 7'h7F, 7'h7F, 1'b0);
            put_move(8'h62, 8'h90, 16'(t));
            put_park(8'h64);
            beam_v = 8'h20; beam_hc = 7'(t - 1);
            start(18'h00060);
            idle(24);
            chk(wcount == 0, "R4 below target holds", wcount, 0);
            beam_hc = 7'(t);
            idle(24);
            chk(wcount == 1 && wl_data[0] == 16'(t), "R4 target reached", wl_data[0], t);
        end
        // R4: vertical outranks horizontal
        put_cmp(8'h60, 8'h20, 7'h7F, 1'b1, 7'h7F, 7'h7F, 1'b0);
        put_move(8'h62, 8'h90, 16'h00EE);
        beam_v = 8'h21; beam_hc = 7'h00;
        start(18'h00060);
        idle(24);
        chk(wcount == 1, "R4 vertical more significant", wcount, 1);
        // R4: zero horizontal mask ignores horizontal
        put_cmp(8'h60, 8'h20, 7'h7F, 1'b1, 7'h7F, 7'h00, 1'b0);
        beam_v = 8'h20;
        start(18'h00060);
        idle(24);
        chk(wcount == 1, "R4 masked horizontal ignored", wcount, 1);

        // R5: vertical bit 7 cannot be masked
        put_cmp(8'h70, 8'h80, 7'h00, 1'b1, 7'h00, 7'h00, 1'b0);
        put_move(8'h72, 8'h91, 16'h0007);
        put_park(8'h74);
        beam_v = 8'h7F; beam_hc = 7'h7F;
        start(18'h00070);
        idle(24);
        chk(wcount == 0, "R5 v7 low holds", wcount, 0);
        beam_v = 8'h80;
        idle(24);
        chk(wcount == 1, "R5 v7 high releases", wcount, 1);

        // R6: blitter qualifier
        put_cmp(8'h78, 8'h00, 7'h00, 1'b0, 7'h7F, 7'h7F, 1'b0);
        put_move(8'h7A, 8'h92, 16'h0008);
        put_park(8'h7C);
        blit_done = 1'b0;
        start(18'h00078);
        idle(24);
        chk(wcount == 0, "R6 waits for blitter", wcount, 0);
        blit_done = 1'b1;
        idle(24);
        chk(wcount == 1, "R6 blitter done releases", wcount, 1);
        blit_done = 1'b0;

        // R7: skip taken and not taken
        put_cmp(8'h80, 8'h10, 7'h00, 1'b1, 7'h7F, 7'h7F, 1'b1);
        put_move(8'h82, 8'h93, 16'h0001);
        put_move(8'h84, 8'h94, 16'h0002);
        put_park(8'h86);
        beam_v = 8'h20; beam_hc = 7'h00;
        start(18'h00080);
        idle(40);
        chk(wcount == 1 && wl_addr[0] == 8'h94, "R7 skip taken", wl_addr[0], 8'h94);
        beam_v = 8'h05;
        start(18'h00080);
        idle(40);
        chk(wcount == 2 && wl_addr[0] == 8'h93, "R7 skip not taken", wcount, 2);

        // R8: program jumps via second strobe
        put_move(8'hC0, 8'h95, 16'h0077);
        put_park(8'hC2);
        put_move(8'hB0, 8'h55, 16'h0000);
        put_move(8'hB2, 8'h96, 16'h0001);
        put_park(8'hB4);
        hwrite(8'h52, 16'h0000);
        hwrite(8'h53, 16'h00C0);
        start(18'h000B0);
        idle(40);
        chk(wcount == 1 && wl_addr[0] == 8'h95, "R8 move strobe jump", wl_addr[0], 8'h95);

        // R9: vblank restart from location 1
        put_cmp(8'hA0, 8'h70, 7'h00, 1'b1, 7'h7F, 7'h7F, 1'b0);
        put_move(8'hA2, 8'h97, 16'h0009);
        put_move(8'hD0, 8'h98, 16'h0003);
        put_park(8'hD2);
        beam_v = 8'h00;
        start(18'h000A0);
        hwrite(8'h51, 16'h00D0);
        idle(24);
        chk(wcount == 0, "R9 location change alone", wcount, 0);
        @(negedge clk); vbl = 1'b1;
        @(negedge clk); vbl = 1'b0;
        idle(24);
        chk(wcount == 1 && wl_addr[0] == 8'h98, "R9 vblank restart", wl_addr[0], 8'h98);

        // R12: fetch across the top of the address space
        mem[8'hFF] = {7'd0, 8'h99, 1'b0};
        mem[8'h00] = 16'h55AA;
        put_park(8'h01);
        start(18'h3FFFF);
        idle(30);
        chk(wcount == 1 && wl_data[0] == 16'h55AA, "R12 wrap data", wl_data[0], 16'h55AA);
        chk(mem_addr == 18'h00003, "R12 wrapped address", mem_addr, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule